// File: doc/BRIEF.md
# Cache miss rate monitor

This block sits beside a cache controller and counts the hit and miss strobes that controller emits, each in a 32-bit counter of its own. Software starts and stops monitoring through a run bit. While monitoring runs, an optional window countdown, paced by a synchronous reference tick (nominally 16 MHz), measures a fixed interval. At the end of that interval the block stops itself and raises a one-clock interrupt pulse. Each counter also has a programmable threshold. The first time a counter climbs to its threshold, the block raises a status bit and an interrupt pulse.

Software reaches the block through a small word-addressed register port. The port is a select, a write enable, a 3-bit word index and 32 data bits, and reads return data combinationally in the same cycle. The register map is as follows:
- Index 0, control/status: bit 0 is run, bit 1 is interrupt enable, bit 2 is window-expired status, bit 3 is hit-threshold status and bit 4 is miss-threshold status.
- Index 1 is the hit count and index 2 is the miss count.
- Index 3 is the 19-bit interval. Its upper bits read 0.
- Index 4 is the hit threshold and index 5 is the miss threshold.
- Indices 6 and 7 read 0.

The run state lives in a three-state machine:
- STOPPED: run is 0, and the countdown reloads from the interval every cycle.
- FREE: running with an interval of 0, so no countdown.
- TIMING: running, with the countdown decremented on each tick.

The machine has these transitions:
- start_timed (STOPPED to TIMING): a run=1 write while the interval is nonzero.
- start_free (STOPPED to FREE): a run=1 write while the interval is 0.
- stop (FREE or TIMING to STOPPED): a run=0 write.
- expire (TIMING to STOPPED): a tick while one count remains. An expiry takes precedence over a write in the same cycle.

Top module: `miss_rate_monitor`

## Requirements
- R1: After reset every register reads 0, the run bit is 0 and irq_o is 0.
- R2: While run is 1, each cycle with hit_i high adds one to the hit count and each cycle with miss_i high adds one to the miss count. Both strobes in one cycle count once each. A count wraps from 0xFFFFFFFF to 0.
- R3: While run is 0, hit_i and miss_i have no effect on the counts.
- R4: A write to index 1 or 2 loads that count. Setting run from 0 to 1 leaves the counts unchanged.
- R5: With run 1 and a nonzero interval N, the window ends on the N-th reference tick. On that tick run returns to 0, control bit 2 is set and a pulse is raised.
- R6: With an interval of 0, run stays 1 however many ticks arrive, and bit 2 is never set.
- R7: Stopping with a run=0 write reloads the countdown, so a later start begins a full window of N ticks.
- R8: When a hit strobe brings the hit count equal to a nonzero hit threshold, control bit 3 is set and one pulse is raised. Further hits do not pulse again.
- R9: When a miss strobe brings the miss count equal to a nonzero miss threshold, control bit 4 is set and one pulse is raised.
- R10: A threshold of 0 never sets its status bit and never raises a pulse.
- R11: With control bit 1 at 0, status bits are still set, but irq_o stays 0.
- R12: Status bits stay set until software writes 0 to them. Writing 1 to a status bit leaves it unchanged. irq_o is high for exactly one clock per event cycle, in the cycle after the event was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Cache hit strobe |
| miss_i | input | 1 | Cache miss strobe |
| ref_tick_i | input | 1 | Reference tick enable for the window countdown |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 3 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the index |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The counters are driven in several patterns: single hits, single misses, both strobes in one cycle, strobes while stopped, and an increment from all-ones. These patterns separate correct counting from double counting, from counting while stopped and from a wrong wrap. Windows of 3 and 5 ticks are run, including a stop and restart partway through, which exposes off-by-one expiry and a missing reload. The interval-0 case shows that no timed stop happens. Thresholds are approached one event at a time, with the interrupt pulse observed in each cycle, so that a pulse that fires early, fires twice or fires while masked shows up.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
    localparam int CNT_W   = 32;
    localparam int IVAL_W  = 19;
    localparam int ADDR_W  = 3;
    localparam int N_SRC   = 2;   // event counters: 0 hit, 1 miss

    localparam logic [ADDR_W-1:0] IDX_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_HCNT = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_MCNT = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_IVAL = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_HTHR = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_MTHR = 3'd5;

    localparam int B_RUN  = 0;
    localparam int B_IEN  = 1;
    localparam int B_WIN  = 2;
    localparam int B_HTHR = 3;
    localparam int B_MTHR = 4;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_FREE    = 2'd1,
        ST_TIMING  = 2'd2
    } win_state_t;
endpackage

// File: rtl/mrm_event_ctr.sv
module mrm_event_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         strobe_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] thr_i,
    output logic [W-1:0] count_o,
    output logic         reach_o
);
    logic [W-1:0] count_q;
    logic [W-1:0] count_inc;
    logic         bump;

    assign bump      = run_i && strobe_i && !wr_i;
    assign count_inc = count_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (wr_i)   count_q <= wr_data_i;
        else if (bump)   count_q <= count_inc;
    end

    assign reach_o = bump && (thr_i != '0) && (count_inc == thr_i);
    assign count_o = count_q;

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i) |=> $stable(count_o));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && strobe_i && !wr_i) |=> (count_o == $past(count_o) + 1'b1));

    // R8
    reach_matches_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reach_o |=> (count_o == $past(thr_i)));
endmodule

// File: rtl/mrm_window.sv
module mrm_window
    import mrm_pkg::*;
#(
    parameter int IW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [IW-1:0] interval_i,
    input  logic          ctrl_wr_i,
    input  logic          run_wdata_i,
    output logic          run_o,
    output logic          expire_o
);
    win_state_t    state_q, state_d;
    logic [IW-1:0] remain_q;
    logic          expire;

    assign expire = (state_q == ST_TIMING) && tick_i && (remain_q == IW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_wr_i && run_wdata_i)
                            state_d = (interval_i != '0) ? ST_TIMING : ST_FREE;
            ST_FREE:    if (ctrl_wr_i && !run_wdata_i) state_d = ST_STOPPED;
            ST_TIMING:  if (expire || (ctrl_wr_i && !run_wdata_i)) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_STOPPED;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STOPPED)            remain_q <= interval_i;
            else if (state_q == ST_TIMING && tick_i) remain_q <= remain_q - 1'b1;
        end
    end

    always_comb begin
        run_o    = (state_q != ST_STOPPED);
        expire_o = expire;
    end

    // R5
    expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !run_o);

    // R6
    stop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> ($past(expire_o) || $past(ctrl_wr_i && !run_wdata_i)));

    // R7
    timing_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMING) |-> (remain_q != '0));
endmodule

// File: rtl/mrm_regs.sv
module mrm_regs
    import mrm_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 19,
    parameter int AW = 3,
    parameter int NS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [W-1:0]         wdata_i,
    output logic [W-1:0]         rdata_o,
    input  logic                 run_i,
    input  logic                 expire_i,
    input  logic [NS-1:0]        reach_i,
    input  logic [NS-1:0][W-1:0] count_i,
    output logic                 ctrl_wr_o,
    output logic [NS-1:0]        cnt_wr_o,
    output logic [NS-1:0][W-1:0] thr_o,
    output logic [IW-1:0]        interval_o,
    output logic                 irq_o
);
    logic                 wr;
    logic                 irq_en_q;
    logic [2:0]           status_q;   // {miss thr, hit thr, window}
    logic [2:0]           set_evt;
    logic [IW-1:0]        interval_q;
    logic [NS-1:0][W-1:0] thr_q;
    logic                 irq_q;

    assign wr        = sel_i && we_i;
    assign ctrl_wr_o = wr && (addr_i == IDX_CTRL);
    assign cnt_wr_o[0] = wr && (addr_i == IDX_HCNT);
    assign cnt_wr_o[1] = wr && (addr_i == IDX_MCNT);
    assign set_evt   = {reach_i[1], reach_i[0], expire_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q   <= 1'b0;
            status_q   <= '0;
            interval_q <= '0;
            thr_q      <= '0;
            irq_q      <= 1'b0;
        end else begin
            if (ctrl_wr_o) begin
                irq_en_q <= wdata_i[B_IEN];
                status_q <= (status_q & wdata_i[B_MTHR:B_WIN]) | set_evt;
            end else begin
                status_q <= status_q | set_evt;
            end
            if (wr && addr_i == IDX_IVAL) interval_q <= wdata_i[IW-1:0];
            if (wr && addr_i == IDX_HTHR) thr_q[0] <= wdata_i;
            if (wr && addr_i == IDX_MTHR) thr_q[1] <= wdata_i;
            irq_q <= irq_en_q && (|set_evt);
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            IDX_CTRL: rdata_o = W'({status_q, irq_en_q, run_i});
            IDX_HCNT: rdata_o = count_i[0];
            IDX_MCNT: rdata_o = count_i[1];
            IDX_IVAL: rdata_o = W'(interval_q);
            IDX_HTHR: rdata_o = thr_q[0];
            IDX_MTHR: rdata_o = thr_q[1];
            default:  rdata_o = '0;
        endcase
    end

    assign thr_o      = thr_q;
    assign interval_o = interval_q;
    assign irq_o      = irq_q;

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq_en_q));

    // R12
    status_rise_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_q[0]) || $rose(status_q[1]) || $rose(status_q[2]))
            |-> (irq_o || !$past(irq_en_q)));

    // R12
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr_o && $past(1'b1)) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/miss_rate_monitor.sv
module miss_rate_monitor
    import mrm_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int IW = IVAL_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          miss_i,
    input  logic          ref_tick_i,
    input  logic          bus_sel_i,
    input  logic          bus_we_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [CW-1:0] bus_wdata_i,
    output logic [CW-1:0] bus_rdata_o,
    output logic          irq_o
);
    localparam int NS = N_SRC;

    logic                  run;
    logic                  expire;
    logic                  ctrl_wr;
    logic [NS-1:0]         strobe;
    logic [NS-1:0]         cnt_wr;
    logic [NS-1:0]         reach;
    logic [NS-1:0][CW-1:0] count;
    logic [NS-1:0][CW-1:0] thr;
    logic [IW-1:0]         interval;

    assign strobe = {miss_i, hit_i};

    mrm_window #(.IW(IW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ref_tick_i),
        .interval_i (interval),
        .ctrl_wr_i  (ctrl_wr),
        .run_wdata_i(bus_wdata_i[B_RUN]),
        .run_o      (run),
        .expire_o   (expire)
    );

    for (genvar g = 0; g < NS; g++) begin : g_ctr
        mrm_event_ctr #(.W(CW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run),
            .strobe_i (strobe[g]),
            .wr_i     (cnt_wr[g]),
            .wr_data_i(bus_wdata_i),
            .thr_i    (thr[g]),
            .count_o  (count[g]),
            .reach_o  (reach[g])
        );
    end

    mrm_regs #(.W(CW), .IW(IW), .AW(AW), .NS(NS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .rdata_o   (bus_rdata_o),
        .run_i     (run),
        .expire_i  (expire),
        .reach_i   (reach),
        .count_i   (count),
        .ctrl_wr_o (ctrl_wr),
        .cnt_wr_o  (cnt_wr),
        .thr_o     (thr),
        .interval_o(interval),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/miss_rate_monitor_tb.sv
module miss_rate_monitor_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_i = 1'b0, miss_i = 1'b0, ref_tick_i = 1'b0;
    logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic last_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    miss_rate_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .miss_i(miss_i),
        .ref_tick_i(ref_tick_i), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        last_irq = irq_o;
        bus_sel_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic step(input logic h, input logic m, input logic t);
        @(negedge clk);
        hit_i = h; miss_i = m; ref_tick_i = t;
        @(negedge clk);
        last_irq = irq_o;
        hit_i = 1'b0; miss_i = 1'b0; ref_tick_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        do_reset();
        step(1, 0, 0);
        rd(1, d); chk("R3 hit ignored while stopped", d, 0);
        step(0, 1, 0);
        rd(2, d); chk("R3 miss ignored while stopped", d, 0);
        wr(1, 32'd40);
        wr(0, 32'h1);
        rd(1, d); chk("R4 start keeps count", d, 40);
        step(1, 0, 0); step(1, 0, 0);
        rd(1, d); chk("R2 two hits", d, 42);
        step(1, 1, 0);
        rd(1, d); chk("R2 joint hit", d, 43);
        rd(2, d); chk("R2 joint miss", d, 1);
        wr(0, 32'h0);
        step(1, 1, 0);
        rd(1, d); chk("R3 hold after stop", d, 43);
        wr(1, 32'hFFFF_FFFF);
        wr(0, 32'h1);
        step(1, 0, 0);
        rd(1, d); chk("R2 wrap", d, 0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        do_reset();
        wr(3, 32'd3);
        wr(0, 32'h3);
        step(0, 0, 1); chk("R5 no pulse tick1", {31'h0, last_irq}, 0);
        step(0, 0, 1); chk("R5 no pulse tick2", {31'h0, last_irq}, 0);
        rd(0, d); chk("R5 still running", d, 32'h3);
        step(0, 0, 1); chk("R5 pulse tick3", {31'h0, last_irq}, 1);
        @(negedge clk);
        chk("R12 pulse one cycle", {31'h0, irq_o}, 0);
        rd(0, d); chk("R5 stopped with status", d, 32'h6);
        wr(0, 32'h6);
        rd(0, d); chk("R12 write 1 keeps status", d, 32'h6);
        wr(0, 32'h2);
        rd(0, d); chk("R12 write 0 clears status", d, 32'h2);
        // reload on stop
        wr(3, 32'd5);
        wr(0, 32'h3);
        step(0, 0, 1); step(0, 0, 1);
        wr(0, 32'h2);
        wr(0, 32'h3);
        for (int i = 0; i < 4; i++) step(0, 0, 1);
        rd(0, d); chk("R7 full window after restart", d, 32'h3);
        step(0, 0, 1); chk("R7 pulse on fifth tick", {31'h0, last_irq}, 1);
    endtask

    task automatic t_zero_ival();
        logic [31:0] d;
        do_reset();
        wr(0, 32'h3);
        for (int i = 0; i < 6; i++) step(0, 0, 1);
        rd(0, d); chk("R6 interval 0 keeps running", d, 32'h3);
    endtask

    task automatic t_thresholds();
        logic [31:0] d;
        do_reset();
        wr(4, 32'd3);
        wr(5, 32'd2);
        wr(0, 32'h3);
        step(1, 0, 0); chk("R8 no pulse hit1", {31'h0, last_irq}, 0);
        step(1, 0, 0); chk("R8 no pulse hit2", {31'h0, last_irq}, 0);
        step(1, 0, 0); chk("R8 pulse at hit3", {31'h0, last_irq}, 1);
        step(1, 0, 0); chk("R8 no repeat hit4", {31'h0, last_irq}, 0);
        rd(0, d); chk("R8 hit status", d, 32'hB);
        step(0, 1, 0); chk("R9 no pulse miss1", {31'h0, last_irq}, 0);
        step(0, 1, 0); chk("R9 pulse miss2", {31'h0, last_irq}, 1);
        rd(0, d); chk("R9 miss status", d, 32'h1B);
        // masked
        do_reset();
        wr(4, 32'd1);
        wr(0, 32'h1);
        step(1, 0, 0); chk("R11 masked no pulse", {31'h0, last_irq}, 0);
        rd(0, d); chk("R11 status still set", d, 32'h9);
        // zero thresholds
        do_reset();
        wr(0, 32'h3);
        for (int i = 0; i < 3; i++) begin
            step(1, 1, 0);
            chk("R10 zero threshold no pulse", {31'h0, last_irq}, 0);
        end
        rd(0, d); chk("R10 no status", d, 32'h3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_count();
        t_window();
        t_zero_ival();
        t_thresholds();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule